// File: doc/BRIEF.md
# Programmable Watchdog Timer with Reset/Interrupt Steering

This block is a watchdog timer controlled through one byte-wide control register and observed through a status register. The control byte packs three fields: a steering bit (bit 7), a five-bit multiplier (bits 6:2) and a two-bit resolution code (bits 1:0). The timeout is counted in periods of an external 16 Hz tick. It lasts multiplier × 4^resolution ticks, so it runs from one sixteenth of a second up to 1984 ticks (124 s).

Software keeps the watchdog alive by touching the control register. Writing the register loads a new setting and restarts the count. Reading it restarts the count with the setting already held. If neither happens before the count runs out, the block sets the expiry flag. The steering bit then picks the action. With the bit set, the block requests a system reset, strobes a clear of the century bit that is kept elsewhere, and clears the control register. With the bit clear, it raises a single interrupt pulse. The watchdog is one-shot and stays idle after expiry until it is restarted.

Top module: `wdt_steer`

## Requirements
- R1: After a restart with multiplier M (bits 6:2) and resolution code E (bits 1:0), expiry happens on the (M × 4^E)-th tick pulse. The action outputs are high for exactly the one clock cycle after the clock edge that samples that tick.
- R2: A control value whose multiplier field is zero, including 0x00, leaves the watchdog disarmed. No number of ticks then causes an expiry.
- R3: A write with sel_i=0 stores the byte in the control register, clears the expiry flag and restarts the count from the new value.
- R4: A read with sel_i=0 returns the stored control byte, clears the expiry flag and restarts the count from the stored value. If a read and a write to the control register fall in the same cycle, the write decides the reload value.
- R5: On expiry the expiry flag is set. A read with sel_i=1 then returns 0x80, because the flag is bit 7 and all other bits read as zero. The watchdog does not expire again until it is restarted.
- R6: On expiry with control bit 7 set, rst_req_o and century_clr_o each pulse for one cycle, irq_o stays low, and the control register reads 0x00 afterwards.
- R7: On expiry with control bit 7 clear, irq_o pulses for one cycle, rst_req_o and century_clr_o stay low, and the control byte is kept.
- R8: A write with sel_i=1, which addresses the status register, changes neither the flag nor the control register nor the count.
- R9: A restart in the same cycle as the tick that would expire the count takes priority. No action is taken and the count starts again.
- R10: While reset is asserted, and after it is released, the control register reads 0x00, the flag reads 0, all action outputs are low and the count is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | 16 Hz time base, one clock cycle wide per period |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| sel_i | input | 1 | Register select: 0 control, 1 status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register (combinational) |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | One-cycle interrupt pulse |
| century_clr_o | output | 1 | One-cycle strobe to clear the external century bit |

## Verification
The case that needs care is a software restart (a control write or read) in the same clock cycle as the tick that brings the count to its end. The bench provokes it directly by arming a one-tick timeout and then driving the tick together with a write, and again together with a read. It also lets random stimulus collide the two often, using short timeouts and a high tick rate. The bench judges each case against a reference model in which the restart wins: no action output fires in that cycle, and the next expiry comes one full timeout later.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  parameter int MULT_W   = 5;
  parameter int RES_W    = 2;
  parameter int REG_W    = 1 + MULT_W + RES_W;
  parameter int STEER_B  = REG_W - 1;
  parameter int FLAG_B   = REG_W - 1;
  // Count width: the multiplier shifted left by the largest 4^E exponent.
  parameter int CNT_W    = MULT_W + 2 * ((1 << RES_W) - 1);

  function automatic logic [CNT_W-1:0] timeout_of(input logic [REG_W-1:0] v);
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
    mult = v[RES_W +: MULT_W];
    res  = v[RES_W-1:0];
    return CNT_W'(mult) << {res, 1'b0};
  endfunction
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    // A restart in the same cycle suppresses expiry.
    expire_o = tick_i && !load_i && (cnt_q == CNT_W'(1));
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = load_val_i;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i)); // R3
  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q)); // R1
  AST_DISARMED_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> cnt_q == '0); // R2
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             expire_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic             flag_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             rst_req_o,
  output logic             irq_o,
  output logic             century_clr_o
);
  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic             ctrl_en;
  logic             flag_q, flag_d, flag_en;
  logic             rst_q, rst_d, irq_q, irq_d;

  always_comb begin
    load_o     = !sel_i && (wr_i || rd_i);
    load_val_o = wr_i ? timeout_of(wdata_i) : timeout_of(ctrl_q);
    ctrl_d     = ctrl_q;
    ctrl_en    = 1'b0;
    flag_d     = flag_q;
    flag_en    = 1'b0;
    if (load_o) begin
      flag_d  = 1'b0;
      flag_en = 1'b1;
    end
    if (wr_i && !sel_i) begin
      ctrl_d  = wdata_i;
      ctrl_en = 1'b1;
    end
    if (expire_i) begin
      flag_d  = 1'b1;
      flag_en = 1'b1;
      if (ctrl_q[STEER_B]) begin
        ctrl_d  = '0;
        ctrl_en = 1'b1;
      end
    end
    rst_d = expire_i &&  ctrl_q[STEER_B];
    irq_d = expire_i && !ctrl_q[STEER_B];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      rst_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (flag_en) flag_q <= flag_d;
      rst_q <= rst_d;
      irq_q <= irq_d;
    end
  end

  assign ctrl_o        = ctrl_q;
  assign flag_o        = flag_q;
  assign rst_req_o     = rst_q;
  assign irq_o         = irq_q;
  assign century_clr_o = rst_q;

  AST_FLAG_ON_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> flag_q); // R5
  AST_STEER_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && ctrl_q[STEER_B]) |=> (ctrl_q == '0) && rst_req_o && !irq_o); // R6
  AST_IRQ_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !ctrl_q[STEER_B]) |=> $stable(ctrl_q) && irq_o && !rst_req_o); // R7
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || rst_req_o) |=> !(irq_o || rst_req_o)); // R1
  AST_STATUS_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i && !expire_i) |=> $stable(ctrl_q) && $stable(flag_q)); // R8
endmodule

// File: rtl/wdt_steer.sv
module wdt_steer
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             rst_req_o,
  output logic             irq_o,
  output logic             century_clr_o
);
  logic             rst_n;
  logic             expire;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [REG_W-1:0] ctrl;
  logic             flag;

  wdt_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  wdt_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .wr_i         (wr_i),
    .rd_i         (rd_i),
    .sel_i        (sel_i),
    .wdata_i      (wdata_i),
    .expire_i     (expire),
    .ctrl_o       (ctrl),
    .flag_o       (flag),
    .load_o       (load),
    .load_val_o   (load_val),
    .rst_req_o    (rst_req_o),
    .irq_o        (irq_o),
    .century_clr_o(century_clr_o)
  );

  wdt_countdown u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .tick_i    (tick_i),
    .load_i    (load),
    .load_val_i(load_val),
    .expire_o  (expire)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_i) rdata_o[FLAG_B] = flag;
    else       rdata_o         = ctrl;
  end

  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(rst_req_o && irq_o)); // R6
  AST_RESTART_WINS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!sel_i && (wr_i || rd_i)) |=> !(rst_req_o || irq_o)); // R9
endmodule

// File: tb/wdt_steer_tb.sv
`timescale 1ns/1ps
module wdt_steer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       tick_i, wr_i, rd_i, sel_i;
  logic [7:0] wdata_i, rdata_o;
  logic       rst_req_o, irq_o, century_clr_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // Reference model state
  logic [7:0] m_ctrl;
  logic       m_flag;
  int         m_cnt;
  logic [2:0] m_act;   // {rst_req, irq, century_clr}

  always #2.5 clk_i = ~clk_i;

  wdt_steer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i), .rd_i(rd_i),
    .sel_i(sel_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rst_req_o(rst_req_o),
    .irq_o(irq_o), .century_clr_o(century_clr_o)
  );

  function automatic int ticks_for(input logic [7:0] v);
    int mult = int'(v[6:2]);
    int res  = int'(v[1:0]);
    int scale = 1;
    for (int i = 0; i < res; i++) scale = scale * 4;
    return mult * scale;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // One clock cycle of stimulus; inputs change at the falling edge.
  task automatic step(input logic wr, input logic rd, input logic sel,
                      input logic [7:0] d, input logic tk, input string tag);
    logic ld, ex;
    wr_i = wr; rd_i = rd; sel_i = sel; wdata_i = d; tick_i = tk;
    #1;
    if (rd) chk({tag, " R4/R5 read"}, rdata_o, sel ? {m_flag, 7'b0} : m_ctrl);
    ld = !sel && (wr || rd);
    ex = tk && !ld && (m_cnt == 1);
    m_act = 3'b000;
    if (ld) begin
      if (wr) m_ctrl = d;
      m_cnt  = ticks_for(m_ctrl);
      m_flag = 1'b0;
    end else if (tk && m_cnt != 0) begin
      m_cnt--;
    end
    if (ex) begin
      m_flag = 1'b1;
      if (m_ctrl[7]) begin m_ctrl = 8'h00; m_act = 3'b101; end
      else           m_act = 3'b010;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk({tag, " R1/R6/R7 actions"}, {5'b0, rst_req_o, irq_o, century_clr_o}, {5'b0, m_act});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "idle");
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, tag);
  endtask

  task automatic do_reset;
    rst_ni = 1'b0;
    wr_i = 0; rd_i = 0; sel_i = 0; wdata_i = 0; tick_i = 0;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R10 action outputs in reset", {5'b0, rst_req_o, irq_o, century_clr_o}, 8'h00);
    rst_ni = 1'b1;
    m_ctrl = 8'h00; m_flag = 1'b0; m_cnt = 0; m_act = 3'b000;
    repeat (3) @(negedge clk_i);
  endtask

  // Count ticks until an action fires; returns count, or -1 past limit.
  task automatic ticks_to_action(input int limit, output int n, output logic [2:0] act);
    n = -1; act = 3'b000;
    for (int i = 1; i <= limit; i++) begin
      step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, "count");
      if (rst_req_o || irq_o || century_clr_o) begin
        n = i; act = {rst_req_o, irq_o, century_clr_o};
        break;
      end
    end
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [2:0] a;
    void'($urandom(32'd1357));
    do_reset();

    // R10: reset state
    step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0, "R10 ctrl after reset");
    step(1'b0, 1'b1, 1'b1, 8'h00, 1'b0, "R10 flag after reset");
    ticks_to_action(50, n, a);
    chk("R10 no expiry after reset", 8'(n), 8'hFF);

    // R1/R7: 0x05 -> M=1,E=1 -> 4 ticks, interrupt
    step(1'b1, 1'b0, 1'b0, 8'h05, 1'b0, "R3 write");
    ticks_to_action(20, n, a);
    chk("R1 ticks for 0x05", 8'(n), 8'd4);
    chk("R7 irq only", {5'b0, a}, 8'h02);
    step(1'b0, 1'b1, 1'b1, 8'h00, 1'b0, "R5 flag set");
    chk("R5 flag value", rdata_o, 8'h80);
    ticks_to_action(40, n, a);
    chk("R5 one-shot", 8'(n), 8'hFF);
    step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0, "R7 ctrl kept");
    chk("R7 ctrl kept literal", rdata_o, 8'h05);

    // R4: that read restarted count and cleared flag
    step(1'b0, 1'b1, 1'b1, 8'h00, 1'b0, "R4 flag cleared by read");
    chk("R4 flag literal", rdata_o, 8'h00);
    ticks_to_action(20, n, a);
    chk("R4 read restarts", 8'(n), 8'd4);

    // R6: steer to reset, 0x8A -> M=2,E=2 -> 32 ticks
    step(1'b1, 1'b0, 1'b0, 8'h8A, 1'b0, "R3 write steer");
    ticks_to_action(100, n, a);
    chk("R6 ticks for 0x8A", 8'(n), 8'd32);
    chk("R6 reset and century", {5'b0, a}, 8'h05);
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R6 pulse ends");
    step(1'b0, 1'b1, 1'b1, 8'h00, 1'b0, "R6 flag");
    chk("R6 flag literal", rdata_o, 8'h80);
    step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0, "R6 ctrl cleared");
    chk("R6 ctrl literal", rdata_o, 8'h00);

    // R2: zero multiplier disarms
    step(1'b1, 1'b0, 1'b0, 8'h83, 1'b0, "R2 write 0x83");
    ticks_to_action(100, n, a);
    chk("R2 zero multiplier", 8'(n), 8'hFF);
    step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R2 write 0x00");
    ticks(30, "R2 disabled");

    // R1 max timeout: 0x7F -> 31*64 = 1984 ticks
    step(1'b1, 1'b0, 1'b0, 8'h7F, 1'b0, "R1 write max");
    ticks_to_action(2100, n, a);
    chk("R1 max timeout low byte", 8'(n), 8'(1984));
    chk("R1 max timeout high", 8'(n >> 8), 8'(1984 >> 8));

    // R9: collision of restart with expiring tick
    step(1'b1, 1'b0, 1'b0, 8'h04, 1'b0, "R9 arm one tick");
    step(1'b1, 1'b0, 1'b0, 8'h04, 1'b1, "R9 write vs tick");
    chk("R9 no action on write collision", {5'b0, rst_req_o, irq_o, century_clr_o}, 8'h00);
    step(1'b0, 1'b1, 1'b0, 8'h00, 1'b1, "R9 read vs tick");
    chk("R9 no action on read collision", {5'b0, rst_req_o, irq_o, century_clr_o}, 8'h00);
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, "R9 next tick expires");
    chk("R9 later expiry", {5'b0, rst_req_o, irq_o, century_clr_o}, 8'h02);

    // R8: status writes ignored
    step(1'b1, 1'b0, 1'b0, 8'h09, 1'b0, "R8 arm 8 ticks");
    ticks(3, "R8 partial");
    step(1'b1, 1'b0, 1'b1, 8'h00, 1'b0, "R8 status write");
    step(1'b1, 1'b0, 1'b1, 8'hFF, 1'b1, "R8 status write with tick");
    ticks_to_action(20, n, a);
    chk("R8 count unaffected", 8'(n), 8'd4);
    step(1'b0, 1'b1, 1'b1, 8'h00, 1'b0, "R8 flag still set");

    // R10: reset mid-count
    step(1'b1, 1'b0, 1'b0, 8'h84, 1'b0, "R10 arm");
    do_reset();
    ticks_to_action(10, n, a);
    chk("R10 count stopped", 8'(n), 8'hFF);
    step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0, "R10 ctrl cleared");

    // Random mix with short timeouts (R1 R3 R4 R5 R6 R7 R8 R9)
    for (int k = 0; k < 6000; k++) begin
      int r = int'($urandom % 100);
      logic tk = ($urandom % 100) < 60;
      logic [7:0] v = {1'($urandom), 3'b0, 2'($urandom % 3), 1'($urandom), 1'b0};
      v[6:2] = 5'($urandom % 4);
      if (r < 5)       step(1'b1, 1'b0, 1'b0, v, tk, "rnd R3 wr");
      else if (r < 8)  step(1'b1, 1'b0, 1'b1, 8'($urandom), tk, "rnd R8 status wr");
      else if (r < 12) step(1'b0, 1'b1, 1'b0, 8'h00, tk, "rnd R4 rd");
      else if (r < 16) step(1'b0, 1'b1, 1'b1, 8'h00, tk, "rnd R5 rd");
      else if (r < 18) step(1'b1, 1'b1, 1'b0, v, tk, "rnd R4 wr+rd");
      else             step(1'b0, 1'b0, 1'b0, 8'h00, tk, "rnd R9 tick");
    end

    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule